// File: doc/BRIEF.md
# Sixteen-bit operate-instruction core

This block is a small single-issue processor that executes only the arithmetic and logic operate instructions of a classic 16-bit teaching architecture: addition, bitwise AND and bitwise inversion. After reset it fetches from a fixed start address. It completes one instruction in every clock cycle. In that cycle it decodes the fields, reads two operands from an eight-entry register file, and writes the result back on the closing clock edge.

The instruction memory lies outside the block. The core drives a word address and expects the addressed word back in the same cycle. When the fetched word is the halt trap word, the core freezes its program counter and raises a halted flag that stays up until the next reset. A debug port reads any register combinationally, so a host or testbench can inspect results without stopping the core.

Top module: `opcore16`

## Requirements
- R1: While reset is high and on the first cycle after it, the fetch address is 0x3000, halted is 0 and every register reads 0 through the debug port.
- R2: Each executed non-halt word advances the fetch address by exactly one on the following clock edge.
- R3: Opcode 0001 (bits 15:12) with bit 5 = 0 writes R[bits 8:6] + R[bits 2:0] into R[bits 11:9].
- R4: For opcodes 0001 and 0101 with bit 5 = 1, bits 4:0 are a two's-complement literal (-16..+15) sign-extended to 16 bits and used as the second operand.
- R5: Opcode 0101 with bit 5 = 0 writes R[bits 8:6] AND R[bits 2:0] into R[bits 11:9].
- R6: Opcode 1001 with bits 5:0 = 111111 writes the bitwise inverse of R[bits 8:6] into R[bits 11:9].
- R7: Addition wraps modulo 2^16, and no flag records the carry.
- R8: The destination may equal a source, and both sources may be the same register. A write lands on the edge that ends its cycle and is visible to the next instruction.
- R9: Fetching 0xF025 sets halted on the next edge. From then on the fetch address and all registers hold until reset.
- R10: Any other opcode, or opcode 1001 whose bits 5:0 differ from 111111, changes no register and only advances the fetch address.
- R11: The debug output always shows the current content of the register selected by the debug select input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| imem_addr | output | 16 | Word address of the instruction being executed |
| imem_data | input | 16 | Instruction word at imem_addr, valid in the same cycle |
| halted | output | 1 | High once the halt word has been fetched |
| dbg_sel | input | 3 | Register index for the debug read |
| dbg_val | output | 16 | Content of the selected register |

## Verification
The bench builds the core with its default parameters: the start address 0x3000 and the halt word 0xF025. Those are the values its programs are laid out for, and they make the halt detection and the freeze of the fetch address observable. Within that setting, two programs cover the following. The first builds 100 in one register through a chain of self-referencing additions. The second covers negative literals, wrap through zero, register-mode AND, inversion, an unknown opcode and an inversion with bad padding, so each decode path and each no-op path is reached.

// File: rtl/opcore16.sv
module opcore16 #(
  parameter logic [15:0] RESET_PC  = 16'h3000,
  parameter logic [15:0] HALT_WORD = 16'hF025
) (
  input  logic        clk,
  input  logic        rst,
  output logic [15:0] imem_addr,
  input  logic [15:0] imem_data,
  output logic        halted,
  input  logic [2:0]  dbg_sel,
  output logic [15:0] dbg_val
);
  localparam int NREG = 8;

  logic [15:0] pc;
  logic [15:0] rf [NREG];
  logic [15:0] opa, opb, res;

  wire [3:0]  op     = imem_data[15:12];
  wire [2:0]  dst    = imem_data[11:9];
  wire [2:0]  src1   = imem_data[8:6];
  wire [2:0]  src2   = imem_data[2:0];
  wire        immsel = imem_data[5];
  wire [15:0] simm   = {{11{imem_data[4]}}, imem_data[4:0]};

  wire do_add  = (op == 4'b0001);
  wire do_and  = (op == 4'b0101);
  wire do_inv  = (op == 4'b1001) && (imem_data[5:0] == 6'h3F);
  wire is_halt = (imem_data == HALT_WORD);
  wire wr_en   = !halted && !is_halt && (do_add || do_and || do_inv);

  assign imem_addr = pc;
  assign dbg_val   = rf[dbg_sel];
  assign opa       = rf[src1];
  assign opb       = immsel ? simm : rf[src2];

  always_comb begin
    if (do_add)      res = opa + opb;
    else if (do_and) res = opa & opb;
    else             res = ~opa;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc     <= RESET_PC;
      halted <= 1'b0;
      for (int i = 0; i < NREG; i++) rf[i] <= '0;
    end else if (!halted) begin
      if (is_halt) halted <= 1'b1;
      else         pc     <= pc + 16'd1;
      if (wr_en) rf[dst] <= res;
    end
  end
endmodule

module opcore16_chk #(
  parameter logic [15:0] RESET_PC  = 16'h3000,
  parameter logic [15:0] HALT_WORD = 16'hF025
) (
  input logic        clk,
  input logic        rst,
  input logic [15:0] imem_addr,
  input logic [15:0] imem_data,
  input logic        halted,
  input logic [2:0]  dbg_sel,
  input logic [15:0] dbg_val
);
  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (imem_addr == RESET_PC) && !halted);

  // R2
  pc_step_chk: assert property (@(posedge clk) disable iff (rst)
    (!halted && imem_data != HALT_WORD) |=> imem_addr == $past(imem_addr) + 16'd1);

  // R9
  halt_set_chk: assert property (@(posedge clk) disable iff (rst)
    (imem_data == HALT_WORD) |=> halted);

  // R9
  halt_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    halted |=> halted && $stable(imem_addr));

  // R9
  halt_regs_chk: assert property (@(posedge clk) disable iff (rst)
    (halted && $stable(dbg_sel)) |=> $stable(dbg_val));
endmodule

bind opcore16 opcore16_chk #(.RESET_PC(RESET_PC), .HALT_WORD(HALT_WORD)) i_chk (.*);

// File: tb/test_opcore16.sv
module test_opcore16;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] imem_addr, imem_data, dbg_val;
  logic        halted;
  logic [2:0]  dbg_sel = '0;

  int n_chk = 0, n_fail = 0;
  logic [15:0] prog [64];

  logic [15:0] m_rf [8];
  logic [15:0] m_pc;
  logic        m_hlt;
  logic [2:0]  m_dr;
  string       m_tag;

  always #5 clk = ~clk;

  function automatic logic [15:0] fetch(input logic [15:0] a);
    logic [15:0] off = a - 16'h3000;
    return (off < 16'd64) ? prog[off[5:0]] : 16'hF025;
  endfunction
  assign imem_data = fetch(imem_addr);

  opcore16 i_opcore16 (.clk(clk), .rst(rst), .imem_addr(imem_addr), .imem_data(imem_data),
                       .halted(halted), .dbg_sel(dbg_sel), .dbg_val(dbg_val));

  function automatic logic [15:0] add_r(int d, int a, int b); return 16'h1000 | 16'(d<<9) | 16'(a<<6) | 16'(b); endfunction
  function automatic logic [15:0] add_i(int d, int a, int k); return 16'h1020 | 16'(d<<9) | 16'(a<<6) | 16'(k & 31); endfunction
  function automatic logic [15:0] and_r(int d, int a, int b); return 16'h5000 | 16'(d<<9) | 16'(a<<6) | 16'(b); endfunction
  function automatic logic [15:0] and_i(int d, int a, int k); return 16'h5020 | 16'(d<<9) | 16'(a<<6) | 16'(k & 31); endfunction
  function automatic logic [15:0] inv(int d, int a); return 16'h903F | 16'(d<<9) | 16'(a<<6); endfunction

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic dump(input string tag);
    for (int r = 0; r < 8; r++) begin
      dbg_sel = 3'(r);
      #1 check(tag, dbg_val, m_rf[r]);
    end
  endtask

  task automatic model_step();
    logic [15:0] w, a, b;
    logic [16:0] s;
    int op;
    if (m_hlt) begin m_tag = "R9"; return; end
    w = fetch(m_pc);
    if (w == 16'hF025) begin m_hlt = 1'b1; m_tag = "R9"; return; end
    op = int'(w[15:12]);
    m_dr = w[11:9];
    a = m_rf[w[8:6]];
    b = w[5] ? {{11{w[4]}}, w[4:0]} : m_rf[w[2:0]];
    m_tag = "R10";
    if (op == 1) begin
      s = {1'b0, a} + {1'b0, b};
      m_rf[m_dr] = s[15:0];
      m_tag = s[16] ? "R7" : (w[5] ? "R4" : "R3");
    end else if (op == 5) begin
      m_rf[m_dr] = a & b;
      m_tag = w[5] ? "R4" : "R5";
    end else if (op == 9 && w[5:0] == 6'h3F) begin
      m_rf[m_dr] = ~a;
      m_tag = "R6";
    end
    if (m_tag != "R10" && (m_dr == w[8:6] || (!w[5] && w[8:6] == w[2:0]))) m_tag = {m_tag, "+R8"};
    m_pc = m_pc + 16'd1;
  endtask

  task automatic run_prog();
    int extra = 0;
    rst = 1'b1;
    m_pc = 16'h3000; m_hlt = 1'b0; m_dr = '0;
    for (int r = 0; r < 8; r++) m_rf[r] = '0;
    @(negedge clk); @(negedge clk);
    check("R1", imem_addr, 16'h3000);
    check("R1", {15'd0, halted}, 16'd0);
    dump("R1");
    @(negedge clk);
    rst = 1'b0;
    #1 check("R1", imem_addr, 16'h3000);
    while (extra < 3) begin
      model_step();
      @(negedge clk);
      check(m_hlt ? "R9" : "R2", imem_addr, m_pc);
      check("R9", {15'd0, halted}, {15'd0, m_hlt});
      dbg_sel = m_dr;
      #1 check(m_tag, dbg_val, m_rf[m_dr]);
      if (m_hlt) extra++;
    end
    dump("R11");
  endtask

  initial begin
    #2000000;
    n_fail++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) prog[i] = 16'hF025;
    prog[0] = and_i(2, 2, 0);
    prog[1] = add_i(2, 2, 15);
    prog[2] = add_i(2, 2, 10);
    prog[3] = add_r(2, 2, 2);
    prog[4] = add_r(2, 2, 2);
    prog[5] = add_i(3, 2, 0);
    prog[6] = 16'hF025;
    prog[7] = add_i(4, 4, 1);
    run_prog();
    check("R8", m_rf[2], 16'd100);

    for (int i = 0; i < 64; i++) prog[i] = 16'hF025;
    prog[0]  = add_i(1, 1, -1);
    prog[1]  = add_i(1, 1, 1);
    prog[2]  = add_i(2, 0, -16);
    prog[3]  = add_i(3, 0, 15);
    prog[4]  = 16'h1283;
    prog[5]  = 16'h12AA;
    prog[6]  = inv(4, 3);
    prog[7]  = and_r(5, 4, 2);
    prog[8]  = and_i(6, 4, -3);
    prog[9]  = 16'h0E3F;
    prog[10] = 16'h9A3E;
    prog[11] = add_r(7, 4, 4);
    prog[12] = add_r(0, 4, 6);
    prog[13] = and_r(5, 5, 5);
    prog[14] = inv(6, 6);
    prog[15] = 16'hF025;
    run_prog();

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule